// File: doc/BRIEF.md
# AHB-Lite Burst Manager with Error Cancellation

This block is a bus manager on an AHB-Lite style bus. A client hands it one command at a time: a start address, a direction, a base write value and a beat count. The manager turns that command into a pipelined run of address and data phases. The first beat goes out as NONSEQ and each later beat as SEQ, with the address rising by one data word per beat. Read data that comes back is forwarded to the client, one pulse per beat. A completion pulse tells the client when the command has ended and whether it failed.

Subordinates signal a failure with a two-cycle error response. In the first cycle the ready input is low and the response input shows ERROR. In the second cycle ready is high and the response still shows ERROR. The manager reacts in the first of those cycles. It withdraws whatever address phase it is presenting and replaces it with IDLE at a parking address, so no later beat of the burst reaches any subordinate. It does this whatever address the withdrawn beat was aimed at. The failing beat's address, direction and index are latched into an error record that stays readable on output ports.

Top module: `ahb_cancel_manager`

## Requirements
- R1: While reset is asserted, bus_trans is IDLE (2'b00), cmd_ready is 1, and done_valid, rd_valid and log_valid are 0.
- R2: A command is taken on a clock edge where cmd_valid and cmd_ready are both 1. In the next cycle bus_trans is NONSEQ (2'b10) and bus_addr equals cmd_addr. cmd_ready stays 0 until the command has completed.
- R3: A command with cmd_len = N issues N+1 beats. Beats after the first are SEQ (2'b11), and each address is the previous one plus DW/8. Once the last beat's address phase has been taken with bus_ready high, bus_trans returns to IDLE and bus_addr keeps that beat's address.
- R4: Outside an error, while bus_ready is low the presented bus_trans, bus_addr and bus_write do not change.
- R5: During the data phase of beat k (k counted from 0), bus_wdata equals cmd_wdata + k. The data phase starts in the cycle after that beat's address phase is taken, and bus_wdata holds while bus_ready is low.
- R6: In a cycle where a data phase is active, bus_ready is 0 and bus_resp is 1 (ERROR; 0 means OKAY), the next cycle shows bus_trans IDLE and bus_addr equal to PARK_ADDR, whatever the target address. No further beat of that command is taken.
- R7: One cycle after the edge on which the final data phase completes, done_valid pulses for one cycle. done_err is 1 if the command ended on an error response and 0 otherwise. cmd_ready is 1 in that cycle.
- R8: For each read beat that completes with OKAY, rd_valid pulses one cycle after the completing edge, and rd_data equals bus_rdata as sampled on that edge.
- R9: On an error response, log_valid becomes 1 and stays 1. log_addr, log_write and log_beat hold the failing beat's address, direction and index, and a later error overwrites them.
- R10: A command that fails immediately after an earlier failed command is handled the same way: same cancellation, its own error completion, and the error record updated to the new failure.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Manager can take a command |
| cmd_addr | input | AW | Address of first beat |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_wdata | input | DW | Base write value; beat k writes base + k |
| cmd_len | input | LENW | Beats minus one |
| done_valid | output | 1 | Command completion pulse |
| done_err | output | 1 | Command ended on an error response |
| rd_valid | output | 1 | Read beat returned |
| rd_data | output | DW | Read beat value |
| bus_trans | output | 2 | Transfer type: 00 IDLE, 10 NONSEQ, 11 SEQ |
| bus_addr | output | AW | Address phase address |
| bus_write | output | 1 | Address phase direction |
| bus_wdata | output | DW | Write data phase value |
| bus_ready | input | 1 | Transfer ready from subordinate |
| bus_resp | input | 1 | Response: 0 OKAY, 1 ERROR |
| bus_rdata | input | DW | Read data from subordinate |
| log_valid | output | 1 | Error record holds an entry |
| log_addr | output | AW | Address of failing beat |
| log_write | output | 1 | Direction of failing beat |
| log_beat | output | LENW | Index of failing beat within its command |

## Verification
The bench builds the block with AW = 32 and DW = 32, so addresses step by 4. It uses LENW = 3, so the longest burst is eight beats and the count limit is reached in a short run. PARK_ADDR is set to 32'hFFFF_F000, which no command address comes near, so a cancelled address phase is easy to tell apart from a held one. The bench's subordinate inserts scripted wait states and can fail any chosen beat. This covers errors on the first beat, a middle beat and the last beat, and two failures in a row, with the command addresses spread across low and high regions.

// File: rtl/ahbm_pkg.sv
package ahbm_pkg;
  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_t;

  localparam logic RESP_OKAY  = 1'b0;
  localparam logic RESP_ERROR = 1'b1;
endpackage

// File: rtl/mgr_addr_stage.sv
// Address phase generator: walks a burst and withdraws it on cancel.
module mgr_addr_stage
  import ahbm_pkg::*;
#(
  parameter int AW = 32,
  parameter int LENW = 4,
  parameter int BYTES = 4,
  parameter logic [AW-1:0] PARK_ADDR = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   st_addr,
  input  logic            st_write,
  input  logic [LENW-1:0] st_len,
  input  logic            adv,
  input  logic            cancel,
  output trans_t          trans,
  output logic [AW-1:0]   addr,
  output logic            write,
  output logic [LENW-1:0] beat,
  output logic            last
);
  trans_t          trans_q;
  logic [AW-1:0]   addr_q;
  logic            write_q;
  logic [LENW-1:0] left_q;
  logic [LENW-1:0] beat_q;
  logic            issuing;
  logic            more;

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a);
    return a + AW'(BYTES);
  endfunction

  assign issuing = adv && (trans_q != TR_IDLE);
  assign more    = (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trans_q <= TR_IDLE;
      addr_q  <= '0;
      write_q <= 1'b0;
      left_q  <= '0;
      beat_q  <= '0;
    end else if (cancel) begin
      trans_q <= TR_IDLE;
      addr_q  <= PARK_ADDR;
      left_q  <= '0;
    end else if (start) begin
      trans_q <= TR_NONSEQ;
      addr_q  <= st_addr;
      write_q <= st_write;
      left_q  <= st_len;
      beat_q  <= '0;
    end else if (issuing) begin
      if (more) begin
        trans_q <= TR_SEQ;
        addr_q  <= step_addr(addr_q);
        left_q  <= left_q - 1'b1;
        beat_q  <= beat_q + 1'b1;
      end else begin
        trans_q <= TR_IDLE;
      end
    end
  end

  assign trans = trans_q;
  assign addr  = addr_q;
  assign write = write_q;
  assign beat  = beat_q;
  assign last  = !more;

  assert_hold_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    (trans_q != TR_IDLE && !adv && !cancel && !start) |=>
      (trans_q == $past(trans_q) && addr_q == $past(addr_q) && write_q == $past(write_q)))
    else $error("address phase moved while ready low");

  assert_step_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    (issuing && more && !cancel && !start) |=>
      (trans_q == TR_SEQ && addr_q == $past(addr_q) + AW'(BYTES)))
    else $error("burst step wrong");

  assert_cancel_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> (trans_q == TR_IDLE && addr_q == PARK_ADDR))
    else $error("cancel did not park address phase");
endmodule

// File: rtl/mgr_data_stage.sv
// Data phase tracker: follows the accepted beat and classifies its response.
module mgr_data_stage
  import ahbm_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LENW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic            resp,
  input  trans_t          a_trans,
  input  logic [AW-1:0]   a_addr,
  input  logic            a_write,
  input  logic [LENW-1:0] a_beat,
  input  logic            a_last,
  input  logic [DW-1:0]   wbase,
  output logic            d_valid,
  output logic [AW-1:0]   d_addr,
  output logic            d_write,
  output logic [LENW-1:0] d_beat,
  output logic            d_last,
  output logic [DW-1:0]   wdata,
  output logic            err_first,
  output logic            fin_err,
  output logic            fin_ok
);
  logic take;

  function automatic logic [DW-1:0] beat_data(input logic [DW-1:0] base,
                                              input logic [LENW-1:0] k);
    return base + DW'(k);
  endfunction

  assign err_first = d_valid && !adv && (resp == RESP_ERROR);
  assign fin_err   = d_valid && adv && (resp == RESP_ERROR);
  assign fin_ok    = d_valid && adv && (resp == RESP_OKAY);
  assign take      = (a_trans != TR_IDLE) && !fin_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_valid <= 1'b0;
      d_addr  <= '0;
      d_write <= 1'b0;
      d_beat  <= '0;
      d_last  <= 1'b0;
      wdata   <= '0;
    end else if (adv) begin
      d_valid <= take;
      if (take) begin
        d_addr  <= a_addr;
        d_write <= a_write;
        d_beat  <= a_beat;
        d_last  <= a_last;
        wdata   <= beat_data(wbase, a_beat);
      end
    end
  end

  assert_no_beat_after_err_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    fin_err |=> !d_valid)
    else $error("data phase followed an error response");

  assert_wdata_hold_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (d_valid && !adv) |=> ($stable(wdata) && $stable(d_addr)))
    else $error("data phase changed while stalled");
endmodule

// File: rtl/mgr_err_log.sv
// Error record: latches the failing beat's details.
module mgr_err_log #(
  parameter int AW = 32,
  parameter int LENW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic [AW-1:0]   c_addr,
  input  logic            c_write,
  input  logic [LENW-1:0] c_beat,
  output logic            log_valid,
  output logic [AW-1:0]   log_addr,
  output logic            log_write,
  output logic [LENW-1:0] log_beat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      log_valid <= 1'b0;
      log_addr  <= '0;
      log_write <= 1'b0;
      log_beat  <= '0;
    end else if (capture) begin
      log_valid <= 1'b1;
      log_addr  <= c_addr;
      log_write <= c_write;
      log_beat  <= c_beat;
    end
  end

  assert_log_sticky_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    log_valid |=> log_valid)
    else $error("error record lost");

  assert_log_capture_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (log_valid && log_addr == $past(c_addr) && log_beat == $past(c_beat)))
    else $error("error record not captured");
endmodule

// File: rtl/ahb_cancel_manager.sv
module ahb_cancel_manager
  import ahbm_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LENW = 4,
  parameter logic [AW-1:0] PARK_ADDR = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [AW-1:0]   cmd_addr,
  input  logic            cmd_write,
  input  logic [DW-1:0]   cmd_wdata,
  input  logic [LENW-1:0] cmd_len,
  output logic            done_valid,
  output logic            done_err,
  output logic            rd_valid,
  output logic [DW-1:0]   rd_data,
  output logic [1:0]      bus_trans,
  output logic [AW-1:0]   bus_addr,
  output logic            bus_write,
  output logic [DW-1:0]   bus_wdata,
  input  logic            bus_ready,
  input  logic            bus_resp,
  input  logic [DW-1:0]   bus_rdata,
  output logic            log_valid,
  output logic [AW-1:0]   log_addr,
  output logic            log_write,
  output logic [LENW-1:0] log_beat
);
  localparam int BYTES = DW / 8;

  // named internal events
  logic            start;
  logic            cancel;
  logic            err_first;
  logic            fin_err;
  logic            fin_ok;
  logic            cmd_end;
  logic            busy_q;
  logic [DW-1:0]   wbase_q;

  trans_t          a_trans;
  logic [AW-1:0]   a_addr;
  logic            a_write;
  logic [LENW-1:0] a_beat;
  logic            a_last;

  logic            d_valid;
  logic [AW-1:0]   d_addr;
  logic            d_write;
  logic [LENW-1:0] d_beat;
  logic            d_last;

  assign cmd_ready = !busy_q;
  assign start     = cmd_valid && !busy_q;
  assign cancel    = err_first || fin_err;
  assign cmd_end   = fin_err || (fin_ok && d_last);

  mgr_addr_stage #(
    .AW(AW), .LENW(LENW), .BYTES(BYTES), .PARK_ADDR(PARK_ADDR)
  ) u_addr (
    .clk(clk), .rst_n(rst_n), .start(start), .st_addr(cmd_addr),
    .st_write(cmd_write), .st_len(cmd_len), .adv(bus_ready), .cancel(cancel),
    .trans(a_trans), .addr(a_addr), .write(a_write), .beat(a_beat), .last(a_last)
  );

  mgr_data_stage #(
    .AW(AW), .DW(DW), .LENW(LENW)
  ) u_data (
    .clk(clk), .rst_n(rst_n), .adv(bus_ready), .resp(bus_resp),
    .a_trans(a_trans), .a_addr(a_addr), .a_write(a_write), .a_beat(a_beat),
    .a_last(a_last), .wbase(wbase_q),
    .d_valid(d_valid), .d_addr(d_addr), .d_write(d_write), .d_beat(d_beat),
    .d_last(d_last), .wdata(bus_wdata),
    .err_first(err_first), .fin_err(fin_err), .fin_ok(fin_ok)
  );

  mgr_err_log #(
    .AW(AW), .LENW(LENW)
  ) u_log (
    .clk(clk), .rst_n(rst_n), .capture(cancel), .c_addr(d_addr),
    .c_write(d_write), .c_beat(d_beat),
    .log_valid(log_valid), .log_addr(log_addr), .log_write(log_write),
    .log_beat(log_beat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      wbase_q <= '0;
    end else if (start) begin
      busy_q  <= 1'b1;
      wbase_q <= cmd_wdata;
    end else if (cmd_end) begin
      busy_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_valid <= 1'b0;
      done_err   <= 1'b0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
    end else begin
      done_valid <= cmd_end;
      done_err   <= fin_err;
      rd_valid   <= fin_ok && !d_write;
      if (fin_ok && !d_write) rd_data <= bus_rdata;
    end
  end

  assign bus_trans = a_trans;
  assign bus_addr  = a_addr;
  assign bus_write = a_write;

  assert_accept_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=>
      (!cmd_ready && bus_trans == TR_NONSEQ && bus_addr == $past(cmd_addr)))
    else $error("command acceptance wrong");

  assert_done_idle_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> (cmd_ready && bus_trans == TR_IDLE))
    else $error("completion reported while bus busy");

  assert_err_cancels_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    (d_valid && !bus_ready && bus_resp) |=> (bus_trans == TR_IDLE))
    else $error("pending address phase not withdrawn");
endmodule

// File: tb/sim_ahb_cancel_manager.sv
module sim_ahb_cancel_manager;
  localparam int PERIOD = 10;
  localparam logic [31:0] PARK = 32'hFFFF_F000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_addr = '0;
  logic        cmd_write = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [2:0]  cmd_len = '0;
  logic        done_valid, done_err, rd_valid;
  logic [31:0] rd_data;
  logic [1:0]  bus_trans;
  logic [31:0] bus_addr, bus_wdata;
  logic        bus_write;
  logic        bus_ready = 1'b1;
  logic        bus_resp = 1'b0;
  logic [31:0] bus_rdata = '0;
  logic        log_valid, log_write;
  logic [31:0] log_addr;
  logic [2:0]  log_beat;

  ahb_cancel_manager #(.AW(32), .DW(32), .LENW(3), .PARK_ADDR(PARK)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_write(cmd_write), .cmd_wdata(cmd_wdata), .cmd_len(cmd_len),
    .done_valid(done_valid), .done_err(done_err), .rd_valid(rd_valid), .rd_data(rd_data),
    .bus_trans(bus_trans), .bus_addr(bus_addr), .bus_write(bus_write), .bus_wdata(bus_wdata),
    .bus_ready(bus_ready), .bus_resp(bus_resp), .bus_rdata(bus_rdata),
    .log_valid(log_valid), .log_addr(log_addr), .log_write(log_write), .log_beat(log_beat)
  );

  always #(PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int acc = 0;
  int rd_cnt = 0;
  int cfg_wait = 0;
  int cfg_err = -1;
  bit finished = 0;

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Behavioural reference: a queue of beat indices still to be presented.
  int          q[$];
  logic [31:0] m_ca = '0, m_base = '0, m_hold = '0;
  bit          m_w = 0, m_busy = 0;
  bit          m_dv = 0, m_dw = 0, m_dl = 0;
  int          m_db = 0;
  logic [31:0] m_da = '0, m_wd = '0;
  bit          m_done = 0, m_derr = 0, m_rdv = 0;
  logic [31:0] m_rd = '0;
  bit          m_lv = 0, m_lw = 0;
  logic [31:0] m_la = '0;
  int          m_lb = 0;
  int          sub_cnt = 0;
  bit          sub_err1 = 0;

  function automatic logic [1:0] exp_trans();
    if (q.size() == 0) return 2'b00;
    return (q[0] == 0) ? 2'b10 : 2'b11;
  endfunction

  function automatic logic [31:0] exp_addr();
    if (q.size() == 0) return m_hold;
    return m_ca + 32'(q[0] * 4);
  endfunction

  always @(posedge clk) begin : model
    bit rdy, rsp, e1, e2, ok, was_busy;
    cyc++;
    if (!rst_n) begin
      q.delete();
      m_ca = '0; m_base = '0; m_hold = '0; m_w = 0; m_busy = 0;
      m_dv = 0; m_dw = 0; m_dl = 0; m_db = 0; m_da = '0; m_wd = '0;
      m_done = 0; m_derr = 0; m_rdv = 0; m_rd = '0;
      m_lv = 0; m_lw = 0; m_la = '0; m_lb = 0;
      sub_cnt = 0; sub_err1 = 0;
    end else begin
      rdy = bus_ready; rsp = bus_resp; was_busy = m_busy;
      e1 = m_dv && !rdy && rsp;
      e2 = m_dv && rdy && rsp;
      ok = m_dv && rdy && !rsp;
      m_done = 0; m_derr = 0; m_rdv = 0;
      if (e1 || e2) begin m_lv = 1; m_la = m_da; m_lw = m_dw; m_lb = m_db; end
      if (ok && !m_dw) begin m_rdv = 1; m_rd = bus_rdata; end
      if (e2 || (ok && m_dl)) begin m_done = 1; m_derr = e2; m_busy = 0; end
      sub_err1 = e1;
      sub_cnt = (m_dv && !rdy) ? sub_cnt + 1 : 0;
      if (rdy) begin
        if (q.size() != 0 && !e2) begin
          m_dv = 1; m_db = q[0]; m_da = exp_addr(); m_dw = m_w;
          m_dl = (q.size() == 1); m_wd = m_base + 32'(q[0]);
          m_hold = m_da;
          void'(q.pop_front());
        end else begin
          m_dv = 0;
        end
      end
      if (e1 || e2) begin
        q.delete();
        m_hold = PARK;
      end else if (cmd_valid && !was_busy) begin
        m_busy = 1; m_ca = cmd_addr; m_w = cmd_write; m_base = cmd_wdata;
        for (int k = 0; k <= int'(cmd_len); k++) q.push_back(k);
      end
    end
  end

  // Subordinate: scripted wait states, optional two-cycle error on one beat.
  always @(negedge clk) begin : sub
    if (!m_dv)                     begin bus_ready = 1'b1; bus_resp = 1'b0; end
    else if (sub_err1)             begin bus_ready = 1'b1; bus_resp = 1'b1; end
    else if (sub_cnt < cfg_wait)   begin bus_ready = 1'b0; bus_resp = 1'b0; end
    else if (m_db == cfg_err)      begin bus_ready = 1'b0; bus_resp = 1'b1; end
    else                           begin bus_ready = 1'b1; bus_resp = 1'b0; end
    bus_rdata = 32'hC0DE_0000 ^ 32'(cyc);
    if (bus_trans != 2'b00 && bus_ready) acc++;
  end

  // Per-cycle comparison against the reference.
  always @(negedge clk) begin : cmp
    if (rst_n && !finished) begin
      chk("R3/R4/R6 bus_trans", bus_trans, exp_trans());
      chk("R2/R3/R6 bus_addr", bus_addr, exp_addr());
      chk("R4 bus_write", bus_write, m_w);
      chk("R5 bus_wdata", bus_wdata, m_wd);
      chk("R2 cmd_ready", cmd_ready, !m_busy);
      chk("R7 done_valid", done_valid, m_done);
      if (m_done) chk("R7 done_err", done_err, m_derr);
      chk("R8 rd_valid", rd_valid, m_rdv);
      if (m_rdv) chk("R8 rd_data", rd_data, m_rd);
      chk("R9 log_valid", log_valid, m_lv);
      if (m_lv) begin
        chk("R9 log_addr", log_addr, m_la);
        chk("R9 log_write", log_write, m_lw);
        chk("R9 log_beat", log_beat, 32'(m_lb));
      end
      if (rd_valid) rd_cnt++;
    end
  end

  task automatic run_cmd(input logic [31:0] a, input bit w, input logic [31:0] d,
                         input int len, input int wt, input int eb, input string tag);
    bit seen = 0;
    acc = 0; rd_cnt = 0;
    cfg_wait = wt; cfg_err = eb;
    @(negedge clk);
    cmd_addr = a; cmd_write = w; cmd_wdata = d; cmd_len = 3'(len); cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R2 cmd_ready low while busy", cmd_ready, 1'b0);
    for (int i = 0; i < 400; i++) begin
      if (done_valid) begin seen = 1; break; end
      @(negedge clk);
    end
    chk({tag, " completion seen"}, seen, 1'b1);
    chk({tag, " done_err"}, done_err, (eb >= 0));
    @(negedge clk);
    chk("R3/R6 beats taken", acc, (eb >= 0) ? eb + 1 : len + 1);
    if (!w && eb < 0) chk("R8 read beats returned", rd_cnt, len + 1);
    if (eb >= 0) begin
      chk({tag, " R9 logged address"}, log_addr, a + 32'(eb * 4));
      chk({tag, " R9 logged direction"}, log_write, w);
      chk({tag, " R9 logged beat"}, log_beat, 3'(eb));
    end
    chk("R6 idle after command", bus_trans, 2'b00);
  endtask

  initial begin : watchdog
    #(PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk("R1 bus_trans in reset", bus_trans, 2'b00);
    chk("R1 cmd_ready in reset", cmd_ready, 1'b1);
    chk("R1 log_valid in reset", log_valid, 1'b0);
    chk("R1 done_valid in reset", done_valid, 1'b0);
    chk("R1 rd_valid in reset", rd_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    run_cmd(32'h0000_1000, 1'b1, 32'h1111_0000, 3, 0, -1, "R7");
    run_cmd(32'h0000_2000, 1'b0, 32'h0,         7, 2, -1, "R7");
    run_cmd(32'h0000_3004, 1'b1, 32'hABCD_0000, 0, 1, -1, "R7");
    run_cmd(32'h0000_4000, 1'b1, 32'h5555_0000, 5, 1,  2, "R7");
    run_cmd(32'h8000_0000, 1'b0, 32'h0,         4, 0,  0, "R10");
    run_cmd(32'h0000_5000, 1'b0, 32'h0,         2, 0,  2, "R10");
    run_cmd(32'h0000_6000, 1'b0, 32'h0,         1, 3, -1, "R7");
    run_cmd(32'h0000_7010, 1'b1, 32'h0F0F_0000, 7, 0, -1, "R7");
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule